// File: doc/BRIEF.md
# Erase Group Sequence Controller

This block follows the three-step erase protocol of a memory card. It receives decoded command events, one per cycle. Each event carries a 6-bit command index and a 32-bit byte address. A start command records the first erase group and an end command records the last one. The erase command then starts a walk over every group in that range, from the first group to the last. The erase-group size is a power of two. It is supplied as log2 of its size in bytes, and every address is rounded down to its group by shifting off the low bits.

During the walk the block presents one group index per cycle on a query port. The write-protect answer for that group comes back in the same cycle. Unprotected groups produce an erase strobe. Protected groups are left alone, and a sticky flag records that a group was skipped.

Commands that arrive out of order within the erase family raise a sequence-error flag and discard the sequence. Any other command that arrives mid-sequence, except the send-status command, raises a sequence-reset flag and also discards the sequence. That command itself is left for the rest of the system to execute.

Top module: `erase_seq_ctrl`

## Requirements
- R1: After a start command (index 35), an end command (index 36) and an erase command (index 38), accepted in that order, the block raises busy on the clock edge that takes the erase command. It then presents the groups from the start group to the end group inclusive, in ascending order, one per cycle. Busy falls after the last group.
- R2: The group index of an address is the address shifted right by grp_log2, so all bits below the group size are ignored.
- R3: An erase-family command out of order sets seq_err and returns the sequence to idle, and no group is erased. Out of order means a start command while a sequence is open, an end command without an open start, or an erase command without a recorded end.
- R4: An erase command whose end group is below its start group sets seq_err, returns the sequence to idle and erases nothing.
- R5: Any command other than indexes 13, 35, 36 and 38 that arrives while a sequence is open sets erase_rst and discards the sequence, so a following end command is out of order. The same command sets no flag when no sequence is open.
- R6: A send-status command (index 13) leaves the sequence state and all status flags unchanged.
- R7: While busy, wp_query_grp carries the current group. erase_stb is high, with erase_grp equal to that group, exactly when wp_protected is low. A protected group sets wp_skip.
- R8: The status flags are sticky until status_clr is pulsed. A clear takes effect on the next edge, and a flag set on that same edge survives the clear.
- R9: Commands presented while busy are ignored.
- R10: After reset, busy, erase_stb and all three status flags are low, and no sequence is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A decoded command event is present |
| cmd_index | input | 6 | Command index of the event |
| cmd_addr | input | 32 | Byte address argument of the event |
| grp_log2 | input | 5 | log2 of the erase-group size in bytes |
| status_clr | input | 1 | One-cycle clear of all status flags |
| wp_protected | input | 1 | Write-protect answer for wp_query_grp, same cycle |
| wp_query_grp | output | 32 | Group index being walked |
| erase_stb | output | 1 | Erase this group now |
| erase_grp | output | 32 | Group index to erase |
| busy | output | 1 | Erase walk in progress |
| seq_err | output | 1 | Sticky flag for an out-of-order erase command |
| erase_rst | output | 1 | Sticky flag for a sequence discarded by another command |
| wp_skip | output | 1 | Sticky flag for a protected group that was skipped |

## Verification
The assertions check the walk on every cycle. Each walk step advances the group by exactly one until the end group, then busy drops, and the current group never passes the end group. They also check that the sequencer sits idle during a walk, that status flags stay set until a clear, and that wp_skip rises only after a protected group was walked. Only the bench scenarios can show the rest. That covers which groups the rounding selects, which command orders raise which flag, that send-status is transparent, that commands are ignored while busy, and the exact set of strobed groups under a protection pattern.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 6;
    localparam int LOG2_W = $clog2(ADDR_W);

    localparam logic [IDX_W-1:0] CMD_STATUS = 6'd13;
    localparam logic [IDX_W-1:0] CMD_START  = 6'd35;
    localparam logic [IDX_W-1:0] CMD_END    = 6'd36;
    localparam logic [IDX_W-1:0] CMD_ERASE  = 6'd38;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_START = 2'd1,
        SQ_END   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic seq_err;
        logic erase_rst;
        logic wp_skip;
    } status_t;

    function automatic logic [ADDR_W-1:0] to_group(input logic [ADDR_W-1:0] addr,
                                                   input logic [LOG2_W-1:0] lg);
        return addr >> lg;
    endfunction
endpackage

// File: rtl/erase_seq_fsm.sv
module erase_seq_fsm
    import erase_seq_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_ok,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [LOG2_W-1:0] grp_log2,
    output seq_state_e        state,
    output logic              walk_go,
    output logic [AW-1:0]     first_grp,
    output logic [AW-1:0]     last_grp,
    output logic              ev_seq_err,
    output logic              ev_erase_rst
);
    seq_state_e      state_n;
    logic [AW-1:0]   grp_in;
    logic            ld_first, ld_last;

    assign grp_in = to_group(cmd_addr, grp_log2);

    always_comb begin
        state_n      = state;
        walk_go      = 1'b0;
        ld_first     = 1'b0;
        ld_last      = 1'b0;
        ev_seq_err   = 1'b0;
        ev_erase_rst = 1'b0;
        if (cmd_ok) begin
            unique case (cmd_index)
                CMD_START: begin
                    if (state == SQ_IDLE) begin
                        ld_first = 1'b1;
                        state_n  = SQ_START;
                    end else begin
                        ev_seq_err = 1'b1;
                        state_n    = SQ_IDLE;
                    end
                end
                CMD_END: begin
                    if (state == SQ_START) begin
                        ld_last = 1'b1;
                        state_n = SQ_END;
                    end else begin
                        ev_seq_err = 1'b1;
                        state_n    = SQ_IDLE;
                    end
                end
                CMD_ERASE: begin
                    state_n = SQ_IDLE;
                    if (state == SQ_END && last_grp >= first_grp) walk_go = 1'b1;
                    else ev_seq_err = 1'b1;
                end
                CMD_STATUS: ;
                default: begin
                    if (state != SQ_IDLE) begin
                        ev_erase_rst = 1'b1;
                        state_n      = SQ_IDLE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            first_grp <= '0;
            last_grp  <= '0;
        end else begin
            state <= state_n;
            if (ld_first) first_grp <= grp_in;
            if (ld_last)  last_grp  <= grp_in;
        end
    end

    // R3
    err_returns_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ev_seq_err |=> state == SQ_IDLE);
endmodule

// File: rtl/erase_walker.sv
module erase_walker
    import erase_seq_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [AW-1:0] first_grp,
    input  logic [AW-1:0] last_grp,
    input  logic          wp_protected,
    output logic          busy,
    output logic [AW-1:0] cur_grp,
    output logic          strobe,
    output logic          skip_evt
);
    logic [AW-1:0] end_q;
    logic          at_end;

    assign at_end   = (cur_grp == end_q);
    assign strobe   = busy && !wp_protected;
    assign skip_evt = busy && wp_protected;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cur_grp <= '0;
            end_q   <= '0;
        end else if (go && !busy) begin
            busy    <= 1'b1;
            cur_grp <= first_grp;
            end_q   <= last_grp;
        end else if (busy) begin
            if (at_end) busy <= 1'b0;
            else        cur_grp <= cur_grp + 1'b1;
        end
    end

    // R1
    walk_step_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !at_end |=> busy && cur_grp == $past(cur_grp) + 1'b1);
    // R1
    walk_done_chk: assert property (@(posedge clk) disable iff (rst)
        busy && at_end |=> !busy);
    // R1
    walk_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> cur_grp <= end_q);
endmodule

// File: rtl/erase_status.sv
module erase_status
    import erase_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  status_t set_ev,
    output status_t flags
);
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (clr ? status_t'('0) : flags) | set_ev;
    end

    // R8
    seq_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        flags.seq_err && !clr |=> flags.seq_err);
    // R8
    erase_rst_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        flags.erase_rst && !clr |=> flags.erase_rst);
endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
    import erase_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LOG2_W-1:0] grp_log2,
    input  logic              status_clr,
    input  logic              wp_protected,
    output logic [ADDR_W-1:0] wp_query_grp,
    output logic              erase_stb,
    output logic [ADDR_W-1:0] erase_grp,
    output logic              busy,
    output logic              seq_err,
    output logic              erase_rst,
    output logic              wp_skip
);
    seq_state_e        state;
    logic              walk_go, ev_seq, ev_rst, skip_evt;
    logic [ADDR_W-1:0] first_grp, last_grp, cur_grp;
    status_t           ev, flags;

    erase_seq_fsm #(.AW(ADDR_W)) u_fsm (
        .clk(clk), .rst(rst),
        .cmd_ok(cmd_valid && !busy),
        .cmd_index(cmd_index), .cmd_addr(cmd_addr), .grp_log2(grp_log2),
        .state(state), .walk_go(walk_go),
        .first_grp(first_grp), .last_grp(last_grp),
        .ev_seq_err(ev_seq), .ev_erase_rst(ev_rst)
    );

    erase_walker #(.AW(ADDR_W)) u_walk (
        .clk(clk), .rst(rst), .go(walk_go),
        .first_grp(first_grp), .last_grp(last_grp),
        .wp_protected(wp_protected),
        .busy(busy), .cur_grp(cur_grp), .strobe(erase_stb), .skip_evt(skip_evt)
    );

    assign ev = '{seq_err: ev_seq, erase_rst: ev_rst, wp_skip: skip_evt};

    erase_status u_stat (
        .clk(clk), .rst(rst), .clr(status_clr), .set_ev(ev), .flags(flags)
    );

    assign wp_query_grp = cur_grp;
    assign erase_grp    = cur_grp;
    assign seq_err      = flags.seq_err;
    assign erase_rst    = flags.erase_rst;
    assign wp_skip      = flags.wp_skip;

    // R9
    idle_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> state == SQ_IDLE);
    // R7
    skip_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wp_skip) |-> $past(busy && wp_protected));
endmodule

// File: tb/tb_erase_seq_ctrl.sv
module tb_erase_seq_ctrl;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0, rst = 1'b1;
    logic        cmd_valid = 1'b0, status_clr = 1'b0, wp_protected;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_addr = '0;
    logic [4:0]  grp_log2 = '0;
    logic [31:0] wp_query_grp, erase_grp;
    logic        erase_stb, busy, seq_err, erase_rst, wp_skip;
    logic        wp_en = 1'b0;
    int          n_chk = 0, n_fail = 0;
    int          s_cnt, s_first, s_last, s_sum, b_cnt;
    bit          s_order_ok;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign wp_protected = wp_en && (wp_query_grp[1:0] == 2'b11);

    erase_seq_ctrl dut (.*);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [5:0] idx, input logic [31:0] a);
        cmd_valid = 1'b1; cmd_index = idx; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic clear_flags();
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
    endtask

    task automatic collect();
        s_cnt = 0; s_sum = 0; b_cnt = 0; s_first = -1; s_last = -1; s_order_ok = 1;
        for (int g = 0; g < 1000 && busy; g++) begin
            b_cnt++;
            if (erase_stb) begin
                if (erase_grp != wp_query_grp) s_order_ok = 0;
                if (s_cnt > 0 && int'(erase_grp) <= s_last) s_order_ok = 0;
                if (s_cnt == 0) s_first = erase_grp;
                s_last = erase_grp; s_sum += erase_grp; s_cnt++;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(!busy && !erase_stb, "R10 busy/strobe after reset", busy, 0);
        chk({seq_err, erase_rst, wp_skip} == 3'b000, "R10 flags after reset",
            {seq_err, erase_rst, wp_skip}, 0);
        send(6'd38, 0);
        chk(seq_err && !busy, "R10 no open sequence after reset", seq_err, 1);
        clear_flags();
    endtask

    task automatic t_basic();
        grp_log2 = 5'd9;
        send(6'd35, 32'h1234);
        send(6'd36, 32'h1A00);
        send(6'd38, 0);
        chk(busy, "R1 busy after erase", busy, 1);
        collect();
        chk(s_cnt == 5 && s_first == 9 && s_last == 13, "R1 R2 strobe count", s_cnt, 5);
        chk(s_sum == 55 && s_order_ok, "R1 ascending groups", s_sum, 55);
        chk({seq_err, erase_rst, wp_skip} == 3'b000, "R1 no flags", {seq_err, erase_rst, wp_skip}, 0);
    endtask

    task automatic t_round();
        grp_log2 = 5'd12;
        send(6'd35, 32'h3FFF);
        send(6'd36, 32'h4000);
        send(6'd38, 32'hFFF);
        collect();
        chk(s_cnt == 2 && s_first == 3 && s_last == 4, "R2 rounding first group", s_first, 3);
    endtask

    task automatic t_wp();
        grp_log2 = 5'd0; wp_en = 1'b1;
        send(6'd35, 0);
        send(6'd36, 7);
        send(6'd38, 0);
        collect();
        chk(b_cnt == 8, "R7 walked cycles", b_cnt, 8);
        chk(s_cnt == 6 && s_sum == 18 && s_order_ok, "R7 unprotected strobes", s_sum, 18);
        chk(wp_skip, "R7 wp_skip set", wp_skip, 1);
        wp_en = 1'b0;
    endtask

    task automatic t_clear();
        send(6'd13, 0);
        chk(wp_skip, "R8 flag sticky", wp_skip, 1);
        clear_flags();
        chk(!wp_skip, "R8 flag cleared", wp_skip, 0);
        status_clr = 1'b1;
        send(6'd36, 0);
        status_clr = 1'b0;
        chk(seq_err, "R8 set wins over clear", seq_err, 1);
        clear_flags();
    endtask

    task automatic t_seq_err();
        send(6'd36, 0);
        chk(seq_err, "R3 end without start", seq_err, 1);
        clear_flags();
        send(6'd35, 64);
        send(6'd35, 128);
        chk(seq_err, "R3 double start", seq_err, 1);
        send(6'd38, 0);
        chk(!busy, "R3 erase after reset sequence no walk", busy, 0);
        clear_flags();
        send(6'd35, 64);
        send(6'd38, 0);
        chk(seq_err && !busy, "R3 erase without end", seq_err, 1);
        clear_flags();
    endtask

    task automatic t_reverse();
        grp_log2 = 5'd4;
        send(6'd35, 32'hA0);
        send(6'd36, 32'h50);
        send(6'd38, 0);
        chk(seq_err && !busy && !erase_stb, "R4 reversed range", busy, 0);
        clear_flags();
    endtask

    task automatic t_other();
        send(6'd17, 0);
        chk(!erase_rst && !seq_err, "R5 no flag when idle", erase_rst, 0);
        send(6'd35, 0);
        send(6'd17, 0);
        chk(erase_rst && !seq_err, "R5 erase_rst mid-sequence", erase_rst, 1);
        send(6'd36, 16);
        chk(seq_err, "R5 sequence discarded", seq_err, 1);
        clear_flags();
    endtask

    task automatic t_status();
        grp_log2 = 5'd0;
        send(6'd35, 20);
        send(6'd13, 0);
        send(6'd36, 22);
        send(6'd13, 0);
        send(6'd38, 0);
        collect();
        chk(s_cnt == 3 && s_first == 20, "R6 status transparent", s_cnt, 3);
        chk({seq_err, erase_rst, wp_skip} == 3'b000, "R6 no flags", {seq_err, erase_rst, wp_skip}, 0);
    endtask

    task automatic t_busy();
        grp_log2 = 5'd0;
        send(6'd35, 100);
        send(6'd36, 105);
        send(6'd38, 0);
        send(6'd35, 0);
        send(6'd38, 0);
        collect();
        chk(s_cnt + 2 == 6 && s_last == 105, "R9 walk unaffected", s_cnt + 2, 6);
        chk(!seq_err, "R9 no flag while busy", seq_err, 0);
        send(6'd36, 0);
        chk(seq_err, "R9 start ignored while busy", seq_err, 1);
        clear_flags();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_round();
        t_wp();
        t_clear();
        t_seq_err();
        t_reverse();
        t_other();
        t_status();
        t_busy();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule